// File: doc/BRIEF.md
# Preloadable Base Timer with Interrupt Request

This block is an 8-bit up-counter that advances once per microsecond. It runs in a 4 MHz system clock domain, and a divide-by-four prescaler supplies a one-cycle clock enable to the counter. A CPU-style write bus has three write-only registers on it:

- a preload register, which loads the counter directly;
- a control register, which holds an active-low run bit and an interrupt mask bit;
- a clear register, which clears the interrupt flag when software writes a one to it.

When the counter rolls from FFh to 00h, a sticky flag is set if the interrupt is unmasked. The flag drives the `irq` line. Software cannot read the flag back.

Software programs an interval of 1 to 256 µs by writing 256 minus the interval to the preload register. After each roll-over the counter carries on from 00h and does not reload. An interval other than 256 µs therefore needs a fresh preload write from the interrupt handler, and that handler also clears the flag.

Top module: `base_tick_timer`

## Requirements
- R1: After reset, `irq` is 0, the counter holds 00h, the timer is halted (control bit 0 = 1) and the interrupt is masked (control bit 1 = 0).
- R2: While the timer runs, the counter advances exactly once every 4 clock cycles. The first advance happens 4 cycles after the bus edge that wrote the run setting.
- R3: Bit 0 of the control register (address C1h) is a level-sensitive halt. While it is 1, the count is frozen. When it returns to 0, counting resumes from the held value.
- R4: A write to the preload register (address C0h) loads the counter on that edge, whether or not the timer is running. The same write restarts the prescaler, so the next advance comes 4 cycles later. A load takes priority over an advance in the same cycle.
- R5: The counter goes from FFh to 00h and keeps counting. The preloaded value is not reloaded.
- R6: A roll-over sets the flag only while bit 1 of the control register is 1. Unmasking the interrupt later does not raise a roll-over that happened while it was masked.
- R7: The flag stays set until the bus writes the clear register (address C2h) with bit 0 = 1. A write to C2h with bit 0 = 0 has no effect.
- R8: If a clear write and a flag-setting roll-over fall on the same edge, the flag stays set.
- R9: `irq` is the registered flag level. It changes on the edge that sets or clears the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| wr_addr | input | 8 | Bus write address (C0h preload, C1h control, C2h clear) |
| wr_data | input | 8 | Bus write data |
| irq | output | 1 | Timer interrupt request (flag level) |

## Verification
The hardest case to reach is an interrupt-clear write that lands on the same edge as a flag-setting roll-over. The same difficulty applies to a halt or preload write that lands on a particular prescaler phase.

The only output is `irq`, so neither the count nor the prescaler phase can be seen directly. The stimulus therefore builds every timing from known anchors: a halted preload, which holds the prescaler phase at zero, then a run write on a recorded edge. From these anchors the stimulus computes the exact edge of each advance and roll-over, and it places the clear, halt or preload write on the edge it needs.

Every expected `irq` level is queued with its cycle number. Each roll-over is confirmed one cycle before it (still low) and on its edge (high).

// File: rtl/btmr_pkg.sv
package btmr_pkg;

  // Decoded write strobes produced by the register block for one bus cycle.
  typedef struct packed {
    logic load;   // preload register written
    logic ctrl;   // control register written
    logic clear;  // clear register written with its clear bit set
  } btmr_wr_t;

endpackage

// File: rtl/btmr_prescale.sv
// Divide-by-DIV clock enable. It is held at phase zero while restart is high.
module btmr_prescale #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);

  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] phase_d;

  assign tick = (phase_q == LAST) && !restart;

  always_comb begin
    if (restart || tick) begin
      phase_d = '0;
    end else begin
      phase_d = phase_q + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_d;
    end
  end

endmodule

// File: rtl/btmr_regs.sv
// Write-only register decode: preload strobe, control bits, clear strobe.
module btmr_regs
  import btmr_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_LOAD = 8'hC0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hC1,
  parameter logic [ADDR_W-1:0] ADDR_CLR  = 8'hC2,
  parameter int          HALT_BIT  = 0,
  parameter int          IE_BIT    = 1,
  parameter int          CLR_BIT   = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output btmr_wr_t          stb,
  output logic              halt,
  output logic              irq_en
);

  logic halt_q, halt_d;
  logic ie_q, ie_d;

  always_comb begin
    stb.load  = wr_en && (wr_addr == ADDR_LOAD);
    stb.ctrl  = wr_en && (wr_addr == ADDR_CTRL);
    stb.clear = wr_en && (wr_addr == ADDR_CLR) && wr_data[CLR_BIT];
  end

  always_comb begin
    halt_d = halt_q;
    ie_d   = ie_q;
    if (stb.ctrl) begin
      halt_d = wr_data[HALT_BIT];
      ie_d   = wr_data[IE_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b1;
      ie_q   <= 1'b0;
    end else begin
      halt_q <= halt_d;
      ie_q   <= ie_d;
    end
  end

  assign halt   = halt_q;
  assign irq_en = ie_q;

endmodule

// File: rtl/btmr_count.sv
// Counter with load priority, free wrap, and sticky overflow flag (set wins).
module btmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             irq_en,
  input  logic             clear,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf_set,
  output logic             flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             flag_q, flag_d;
  logic             adv;
  logic             wrap;

  always_comb begin
    adv  = run && tick && !load;
    wrap = adv && (cnt_q == CNT_MAX);
    ovf_set = wrap && irq_en;

    if (load) begin
      cnt_d = load_val;
    end else if (adv) begin
      cnt_d = cnt_q + CNT_W'(1);
    end else begin
      cnt_d = cnt_q;
    end

    if (ovf_set) begin
      flag_d = 1'b1;
    end else if (clear) begin
      flag_d = 1'b0;
    end else begin
      flag_d = flag_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;

endmodule

// File: rtl/base_tick_timer.sv
module base_tick_timer
  import btmr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int DIV    = 4,
  parameter logic [ADDR_W-1:0] ADDR_LOAD = 8'hC0,
  parameter logic [ADDR_W-1:0] ADDR_CTRL = 8'hC1,
  parameter logic [ADDR_W-1:0] ADDR_CLR  = 8'hC2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              irq
);

  btmr_wr_t         stb_w;
  logic             halt_w;
  logic             ie_w;
  logic             run_w;
  logic             tick_w;
  logic             restart_w;
  logic [CNT_W-1:0] cnt_w;
  logic             ovf_set_w;
  logic             flag_w;

  assign run_w     = !halt_w;
  assign restart_w = !run_w || stb_w.load;

  btmr_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .ADDR_LOAD(ADDR_LOAD),
    .ADDR_CTRL(ADDR_CTRL),
    .ADDR_CLR (ADDR_CLR)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .stb    (stb_w),
    .halt   (halt_w),
    .irq_en (ie_w)
  );

  btmr_prescale #(
    .DIV(DIV)
  ) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .restart(restart_w),
    .tick   (tick_w)
  );

  btmr_count #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_w),
    .tick    (tick_w),
    .load    (stb_w.load),
    .load_val(wr_data[CNT_W-1:0]),
    .irq_en  (ie_w),
    .clear   (stb_w.clear),
    .cnt     (cnt_w),
    .ovf_set (ovf_set_w),
    .flag    (flag_w)
  );

  assign irq = flag_w;

endmodule

// File: rtl/base_tick_timer_chk.sv
module base_tick_timer_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter logic [ADDR_W-1:0] ADDR_LOAD = 8'hC0,
  parameter logic [ADDR_W-1:0] ADDR_CLR  = 8'hC2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              irq,
  input logic              tick,
  input logic              run,
  input logic [CNT_W-1:0]  cnt,
  input logic              ie,
  input logic              ovf_set
);

  logic load_wr;
  logic clr_wr;
  assign load_wr = wr_en && (wr_addr == ADDR_LOAD);
  assign clr_wr  = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

  AST_HALT_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_wr) |=> $stable(cnt)); // R3

  AST_PRELOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt == $past(wr_data[CNT_W-1:0]))); // R4

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load_wr && (cnt == {CNT_W{1'b1}})) |=> (cnt == '0)); // R5

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ie)); // R6

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr_wr) |=> irq); // R7

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_set |=> irq); // R8

endmodule

bind base_tick_timer base_tick_timer_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .CNT_W    (CNT_W),
  .ADDR_LOAD(ADDR_LOAD),
  .ADDR_CLR (ADDR_CLR)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .irq    (irq),
  .tick   (tick_w),
  .run    (run_w),
  .cnt    (cnt_w),
  .ie     (ie_w),
  .ovf_set(ovf_set_w)
);

// File: tb/base_tick_timer_bench.sv
module base_tick_timer_bench;

  localparam int CLK_PERIOD = 250;
  localparam logic [7:0] A_LOAD = 8'hC0;
  localparam logic [7:0] A_CTRL = 8'hC1;
  localparam logic [7:0] A_CLR  = 8'hC2;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       irq;

  base_tick_timer u_base_tick_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .irq    (irq)
  );

  typedef struct {
    int    at;
    logic  val;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   checks = 0;
  int   failures = 0;
  bit   done = 0;

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare queued expectations at the falling edge of their cycle.
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (e.at < cyc) begin
        failures++;
        $display("FAIL %s missed sample at cycle %0d (now %0d) expected=%0b", e.tag, e.at, cyc, e.val);
      end else if (irq !== e.val) begin
        failures++;
        $display("FAIL %s cycle %0d irq actual=%0b expected=%0b", e.tag, cyc, irq, e.val);
      end
    end
  end

  function automatic int nxt();
    return cyc + 1;
  endfunction

  task automatic expect_at(input int at, input logic v, input string tag);
    exp_t e;
    e.at = at; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic goto(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // Called at a falling edge; the write lands on edge cyc+1.
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_addr = '0; wr_data = '0;
  endtask

  // Halt, preload, clear the flag; leaves the prescaler at phase zero.
  task automatic arm(input logic [7:0] p, input bit ie);
    wr(A_CTRL, ie ? 8'h03 : 8'h01);
    wr(A_LOAD, p);
    wr(A_CLR, 8'h01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int e, x, l, d, r;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, irq low.
    expect_at(nxt(), 1'b0, "R1 reset irq");
    // R1/R3: halted out of reset, unmasking alone keeps it frozen.
    e = nxt();
    expect_at(e + 1100, 1'b0, "R3 halted after reset");
    wr(A_CTRL, 8'h03);
    goto(e + 1100);

    // R1/R2/R9: count starts at 00h, 256 ticks of 4 cycles each.
    e = nxt();
    expect_at(e + 1023, 1'b0, "R2 before first overflow");
    expect_at(e + 1024, 1'b1, "R1 R2 R9 overflow from 00h");
    expect_at(e + 1100, 1'b1, "R7 flag sticky");
    wr(A_CTRL, 8'h02);
    goto(e + 1100);
    x = nxt();
    expect_at(x, 1'b1, "R7 clear write with bit0=0 ignored");
    wr(A_CLR, 8'hFE);
    x = nxt();
    expect_at(x, 1'b0, "R7 R9 clear write");
    wr(A_CLR, 8'h01);
    expect_at(e + 2047, 1'b0, "R5 free-running second period");
    expect_at(e + 2048, 1'b1, "R5 second overflow");
    goto(e + 2049);

    // R4/R5: preload F0h, overflow after 16 ticks, then 256 (no reload).
    arm(8'hF0, 1'b1);
    e = nxt();
    expect_at(e + 63, 1'b0, "R4 preload interval");
    expect_at(e + 64, 1'b1, "R4 preload overflow");
    wr(A_CTRL, 8'h02);
    goto(e + 66);
    x = nxt();
    expect_at(x, 1'b0, "R7 clear");
    wr(A_CLR, 8'h01);
    expect_at(e + 128, 1'b0, "R5 no reload of preload");
    expect_at(e + 1087, 1'b0, "R5 wrap before");
    expect_at(e + 1088, 1'b1, "R5 wrap full period");
    goto(e + 1089);

    // R4: preload while running, on a tick edge (load wins).
    arm(8'h00, 1'b1);
    e = nxt();
    wr(A_CTRL, 8'h02);
    goto(e + 39);
    l = nxt();
    expect_at(l + 7, 1'b0, "R4 running preload before");
    expect_at(l + 8, 1'b1, "R4 running preload overflow");
    wr(A_LOAD, 8'hFE);
    goto(l + 9);

    // R3: halt mid-count, hold, resume from held value (F5h).
    arm(8'hF0, 1'b1);
    e = nxt();
    wr(A_CTRL, 8'h02);
    goto(e + 21);
    d = nxt();
    expect_at(d + 400, 1'b0, "R3 frozen while halted");
    wr(A_CTRL, 8'h03);
    goto(d + 400);
    r = nxt();
    expect_at(r + 43, 1'b0, "R3 resume before");
    expect_at(r + 44, 1'b1, "R3 resume from held count");
    wr(A_CTRL, 8'h02);
    goto(r + 45);

    // R6: masked overflow sets nothing, later unmask is not retroactive.
    arm(8'hF0, 1'b0);
    e = nxt();
    expect_at(e + 64, 1'b0, "R6 masked overflow");
    expect_at(e + 70, 1'b0, "R6 masked overflow later");
    wr(A_CTRL, 8'h00);
    goto(e + 70);
    x = nxt();
    expect_at(x + 2, 1'b0, "R6 unmask not retroactive");
    expect_at(e + 1088, 1'b1, "R6 unmasked overflow");
    wr(A_CTRL, 8'h02);
    goto(e + 1089);

    // R8: clear on the overflow edge, set wins.
    arm(8'hF0, 1'b1);
    e = nxt();
    wr(A_CTRL, 8'h02);
    goto(e + 63);
    expect_at(e + 64, 1'b1, "R8 set beats clear");
    expect_at(e + 66, 1'b1, "R8 flag still set");
    wr(A_CLR, 8'h01);
    goto(e + 68);

    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule